// File: doc/BRIEF.md
# Inter-Guest Doorbell Interrupt Register Block

This block is the register face of one endpoint on a shared-memory messaging fabric. Software sees four 32-bit registers on a simple word-aligned read/write bus. The registers hold an interrupt mask, a read-to-clear interrupt status, the endpoint's own node number and a doorbell. A write to the doorbell becomes an outgoing event. The event carries a destination node number and a vector number, and it is handed to the fabric transport over a valid/ready port.

Incoming doorbell events arrive on a single-cycle event port. How they are signalled depends on a mode that is fixed when the block is built. In pin mode an event sets a one-bit status, and a single level interrupt follows mask bit 0 AND that status. In vector mode no status is kept. Each event whose vector is inside the configured vector count produces a one-cycle pulse on that vector's line, and any other event is discarded. The node number and a readiness flag come from outside the block as plain inputs.

A bus access completes in the cycle where `busReq` and `busAck` are both high. Read data is valid in that same cycle. Register writes and read side effects take effect at that cycle's clock edge.

Top module: `doorbell_regblock`

## Requirements
- R1: The registers are decoded from the byte address: offset 0x0 is the mask, 0x4 the status, 0x8 the position and 0xC the doorbell. The mask is a full 32-bit read/write register with reset value 0.
- R2: In pin mode, an incoming event (`inValid` high for one cycle) sets the status register to 1 at that clock edge.
- R3: In pin mode, `irqLevel` equals mask bit 0 AND status. The other mask bits have no effect.
- R4: An accepted read of the status register returns its value and clears it at that edge. If an event arrives in the same cycle, the status ends at 1. Writing the status register changes nothing.
- R5: Reading the position register returns the node ID zero-extended to 32 bits while `nodeReady` is high, and 0xFFFFFFFF while it is low. Writes to it change nothing.
- R6: An accepted doorbell write raises `outValid` on the next cycle, with `outDest` = write data [31:16] and `outVector` = write data [15:0]. Both fields are held until `outReady` is seen high. The doorbell reads as 0.
- R7: A doorbell write is not acknowledged while an earlier event is pending and `outReady` is low. It completes once that event is taken, and no event is lost or reordered.
- R8: In vector mode, an event whose vector is below `VEC_COUNT` drives `irqVec[vector]` high for exactly the next cycle only. Status stays 0 and `irqLevel` stays 0.
- R9: In vector mode, an event whose vector is `VEC_COUNT` or above produces no pulse and has no other effect.
- R10: Addresses that are not word-aligned, or that lie at 0x10 or above, read as 0, and writes to them change nothing.
- R11: In pin mode the vector field of an event is ignored: any value sets the status, and `irqVec` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Bus access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busAck | output | 1 | Access completes this cycle |
| busRdata | output | 32 | Read data, valid with busAck |
| nodeReady | input | 1 | Endpoint has its node number and shared memory |
| nodeId | input | 16 | This endpoint's node number |
| outValid | output | 1 | Outgoing doorbell event pending |
| outReady | input | 1 | Transport takes the pending event |
| outDest | output | 16 | Destination node of the pending event |
| outVector | output | 16 | Vector number of the pending event |
| inValid | input | 1 | Incoming doorbell event strobe |
| inVector | input | 16 | Vector number of the incoming event |
| irqLevel | output | 1 | Level interrupt (pin mode) |
| irqVec | output | VEC_COUNT | Per-vector pulses (vector mode) |

## Verification
The bench builds two copies side by side and drives both with the same bus and event stimulus. One copy is in pin mode and one is in vector mode, and both use a vector count of 4. This makes the mode contrast visible in the same cycle: an event that sets status and the level interrupt in one copy must leave the other copy's status at 0. With a count of 4, the last valid vector (3), the first dropped value (4) and the all-ones vector are all within a few events.

// File: rtl/dbreg_pkg.sv
package dbreg_pkg;
  localparam int REG_W   = 32;
  localparam int FIELD_W = 16;

  typedef enum logic [1:0] {
    SEL_MASK   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_POS    = 2'd2,
    SEL_BELL   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    hit;
    regSel_e sel;
    logic    wrMask;
    logic    rdClrStatus;
    logic    wrBell;
  } busStrobe_t;
endpackage

// File: rtl/dbreg_ctrl.sv
module dbreg_ctrl
  import dbreg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              bellBusy,
  output logic              busAck,
  output busStrobe_t        strobe
);
  logic    aligned;
  logic    inWindow;
  logic    hit;
  regSel_e sel;
  logic    bellStall;

  always_comb begin
    aligned   = (busAddr[1:0] == 2'b00);
    inWindow  = ((busAddr >> 4) == '0);
    hit       = aligned && inWindow;
    sel       = regSel_e'(busAddr[3:2]);
    bellStall = hit && busWrite && (sel == SEL_BELL) && bellBusy;
    busAck    = busReq && !bellStall;

    strobe.hit         = hit;
    strobe.sel         = sel;
    strobe.wrMask      = busAck && busWrite && hit && (sel == SEL_MASK);
    strobe.rdClrStatus = busAck && !busWrite && hit && (sel == SEL_STATUS);
    strobe.wrBell      = busAck && busWrite && hit && (sel == SEL_BELL);
  end
endmodule

// File: rtl/dbreg_vecpulse.sv
module dbreg_vecpulse #(
  parameter int VEC_COUNT = 4,
  parameter int VEC_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [VEC_W-1:0]     inVector,
  output logic [VEC_COUNT-1:0] pulse
);
  genvar i;
  generate
    for (i = 0; i < VEC_COUNT; i++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rstN) pulse[i] <= 1'b0;
        else       pulse[i] <= inValid && (inVector == VEC_W'(i));
      end
    end
  endgenerate
endmodule

// File: rtl/dbreg_datapath.sv
module dbreg_datapath
  import dbreg_pkg::*;
#(
  parameter bit VECTOR_MODE = 1'b0,
  parameter int VEC_COUNT   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strobe,
  input  logic [REG_W-1:0]     busWdata,
  output logic [REG_W-1:0]     busRdata,
  input  logic                 nodeReady,
  input  logic [FIELD_W-1:0]   nodeId,
  output logic                 bellBusy,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [FIELD_W-1:0]   outDest,
  output logic [FIELD_W-1:0]   outVector,
  input  logic                 inValid,
  input  logic [FIELD_W-1:0]   inVector,
  output logic                 irqLevel,
  output logic [VEC_COUNT-1:0] irqVec
);
  logic [REG_W-1:0] maskReg;
  logic             statusReg;

  always_ff @(posedge clk) begin
    if (!rstN)              maskReg <= '0;
    else if (strobe.wrMask) maskReg <= busWdata;
  end

  generate
    if (VECTOR_MODE) begin : g_vector
      assign statusReg = 1'b0;
      assign irqLevel  = 1'b0;
      dbreg_vecpulse #(.VEC_COUNT(VEC_COUNT), .VEC_W(FIELD_W)) u_pulse (
        .clk(clk), .rstN(rstN), .inValid(inValid),
        .inVector(inVector), .pulse(irqVec)
      );
    end else begin : g_pin
      logic statusQ;
      always_ff @(posedge clk) begin
        if (!rstN)                   statusQ <= 1'b0;
        else if (inValid)            statusQ <= 1'b1;
        else if (strobe.rdClrStatus) statusQ <= 1'b0;
      end
      assign statusReg = statusQ;
      assign irqLevel  = maskReg[0] & statusQ;
      assign irqVec    = '0;
    end
  endgenerate

  assign bellBusy = outValid && !outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outDest   <= '0;
      outVector <= '0;
    end else if (strobe.wrBell) begin
      outValid  <= 1'b1;
      outDest   <= busWdata[REG_W-1:FIELD_W];
      outVector <= busWdata[FIELD_W-1:0];
    end else if (outReady) begin
      outValid  <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strobe.hit) begin
      unique case (strobe.sel)
        SEL_MASK:   busRdata = maskReg;
        SEL_STATUS: busRdata = {{(REG_W-1){1'b0}}, statusReg};
        SEL_POS:    busRdata = nodeReady ? {{(REG_W-FIELD_W){1'b0}}, nodeId} : '1;
        SEL_BELL:   busRdata = '0;
        default:    busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/doorbell_regblock.sv
module doorbell_regblock
  import dbreg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter bit VECTOR_MODE = 1'b0,
  parameter int VEC_COUNT   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busReq,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic                 busAck,
  output logic [31:0]          busRdata,
  input  logic                 nodeReady,
  input  logic [15:0]          nodeId,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [15:0]          outDest,
  output logic [15:0]          outVector,
  input  logic                 inValid,
  input  logic [15:0]          inVector,
  output logic                 irqLevel,
  output logic [VEC_COUNT-1:0] irqVec
);
  busStrobe_t strobe;
  logic       bellBusy;

  dbreg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .bellBusy(bellBusy), .busAck(busAck), .strobe(strobe)
  );

  dbreg_datapath #(.VECTOR_MODE(VECTOR_MODE), .VEC_COUNT(VEC_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .nodeReady(nodeReady), .nodeId(nodeId),
    .bellBusy(bellBusy), .outValid(outValid), .outReady(outReady),
    .outDest(outDest), .outVector(outVector), .inValid(inValid),
    .inVector(inVector), .irqLevel(irqLevel), .irqVec(irqVec)
  );
endmodule

// File: rtl/dbreg_checker.sv
module dbreg_checker #(
  parameter int ADDR_W      = 8,
  parameter bit VECTOR_MODE = 1'b0,
  parameter int VEC_COUNT   = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busReq,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busAck,
  input logic [31:0]          busRdata,
  input logic                 nodeReady,
  input logic                 outValid,
  input logic                 outReady,
  input logic [15:0]          outDest,
  input logic [15:0]          outVector,
  input logic                 inValid,
  input logic [15:0]          inVector,
  input logic [VEC_COUNT-1:0] irqVec
);
  logic inRange;
  logic unmapped;
  assign inRange  = ({16'b0, inVector} < 32'(VEC_COUNT));
  assign unmapped = (busAddr[1:0] != 2'b00) || (busAddr >= ADDR_W'(16));

  assert_hold_event_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outDest) && $stable(outVector));

  assert_bell_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busWrite && busAddr == ADDR_W'(12) && outValid && !outReady |-> !busAck);

  assert_pos_notready_R5: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWrite && busAddr == ADDR_W'(8) && !nodeReady |-> busRdata == 32'hFFFF_FFFF);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWrite && unmapped |-> busRdata == 32'h0);

  assert_single_line_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqVec));

  assert_vec_fires_R8: assert property (@(posedge clk) disable iff (!rstN)
    VECTOR_MODE && inValid && inRange |=> irqVec != '0);

  assert_vec_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inRange) |=> irqVec == '0);
endmodule

bind doorbell_regblock dbreg_checker #(
  .ADDR_W(ADDR_W), .VECTOR_MODE(VECTOR_MODE), .VEC_COUNT(VEC_COUNT)
) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
  .busAddr(busAddr), .busAck(busAck), .busRdata(busRdata),
  .nodeReady(nodeReady), .outValid(outValid), .outReady(outReady),
  .outDest(outDest), .outVector(outVector), .inValid(inValid),
  .inVector(inVector), .irqVec(irqVec)
);

// File: tb/doorbell_regblock_bench.sv
`timescale 1ns/1ps
module doorbell_regblock_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 1'b0, busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic nodeReady = 1'b0;
  logic [15:0] nodeId = '0;
  logic outReady = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] inVector = '0;

  logic busAckP, busAckV, outValidP, outValidV, irqLevelP, irqLevelV;
  logic [31:0] busRdataP, busRdataV;
  logic [15:0] outDestP, outDestV, outVectorP, outVectorV;
  logic [3:0] irqVecP, irqVecV;

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ[$];

  always #10 clk = ~clk;

  doorbell_regblock #(.ADDR_W(8), .VECTOR_MODE(1'b0), .VEC_COUNT(4)) u_doorbell_regblock (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAckP), .busRdata(busRdataP), .nodeReady(nodeReady),
    .nodeId(nodeId), .outValid(outValidP), .outReady(outReady), .outDest(outDestP),
    .outVector(outVectorP), .inValid(inValid), .inVector(inVector),
    .irqLevel(irqLevelP), .irqVec(irqVecP));

  doorbell_regblock #(.ADDR_W(8), .VECTOR_MODE(1'b1), .VEC_COUNT(4)) u_doorbell_regblock_vec (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAckV), .busRdata(busRdataV), .nodeReady(nodeReady),
    .nodeId(nodeId), .outValid(outValidV), .outReady(outReady), .outDest(outDestV),
    .outVector(outVectorV), .inValid(inValid), .inVector(inVector),
    .irqLevel(irqLevelV), .irqVec(irqVecV));

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busAccess(input logic wr, input logic [7:0] addr, input logic [31:0] wdata,
                           output logic [31:0] rdP, output logic [31:0] rdV);
    @(negedge clk);
    busReq = 1'b1; busWrite = wr; busAddr = addr; busWdata = wdata;
    #1;
    while (!busAckP) begin
      @(negedge clk); #1;
    end
    rdP = busRdataP; rdV = busRdataV;
    @(negedge clk);
    busReq = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busWr(input logic [7:0] addr, input logic [31:0] wdata);
    logic [31:0] a, b;
    busAccess(1'b1, addr, wdata, a, b);
  endtask

  task automatic ringBell(input logic [31:0] wdata);
    expQ.push_back(wdata);
    busWr(8'h0C, wdata);
  endtask

  task automatic injectEvent(input string req, input logic [15:0] vec, input logic [3:0] expV);
    @(negedge clk);
    inValid = 1'b1; inVector = vec;
    @(negedge clk);
    inValid = 1'b0;
    checkEq(req, 32'(irqVecV), 32'(expV));
    checkEq("R11 pin irqVec quiet", 32'(irqVecP), 32'h0);
    @(negedge clk);
    checkEq({req, " one cycle"}, 32'(irqVecV), 32'h0);
  endtask

  // scoreboard monitor for outgoing doorbell events
  always @(posedge clk) begin
    if (rstN && outValidP && outReady) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R6 unexpected event actual=%h expected=none", {outDestP, outVectorP});
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        checkEq("R6 event fields", {outDestP, outVectorP}, e);
        checkEq("R6 vec-mode copy", {outDestV, outVectorV}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rP, rV;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R3 reset irqLevel", 32'(irqLevelP), 0);
    checkEq("R6 reset outValid", 32'(outValidP), 0);
    checkEq("R8 reset irqVec", 32'(irqVecV), 0);
    busAccess(1'b0, 8'h00, 0, rP, rV);
    checkEq("R1 mask reset", rP, 32'h0);

    // R5 position
    busAccess(1'b0, 8'h08, 0, rP, rV);
    checkEq("R5 not ready", rP, 32'hFFFF_FFFF);
    nodeReady = 1'b1; nodeId = 16'h0023;
    busAccess(1'b0, 8'h08, 0, rP, rV);
    checkEq("R5 ready id", rP, 32'h0000_0023);
    busWr(8'h08, 32'h0000_0055);
    busAccess(1'b0, 8'h08, 0, rP, rV);
    checkEq("R5 write ignored", rP, 32'h0000_0023);
    nodeId = 16'hFFFF;
    busAccess(1'b0, 8'h08, 0, rP, rV);
    checkEq("R5 max id zero-extended", rP, 32'h0000_FFFF);

    // R1/R2/R3 mask and status
    busWr(8'h00, 32'hFFFF_FFFE);
    busAccess(1'b0, 8'h00, 0, rP, rV);
    checkEq("R1 mask readback", rP, 32'hFFFF_FFFE);
    injectEvent("R9 vec 7 dropped", 16'h0007, 4'b0000);
    checkEq("R3 bit0 clear masks", 32'(irqLevelP), 0);
    checkEq("R8 no level in vector mode", 32'(irqLevelV), 0);
    busWr(8'h00, 32'h0000_0001);
    checkEq("R2 R3 level raised", 32'(irqLevelP), 1);

    // R4 status behaviour
    busWr(8'h04, 32'h0);
    checkEq("R4 status write ignored", 32'(irqLevelP), 1);
    busAccess(1'b0, 8'h04, 0, rP, rV);
    checkEq("R4 status read value", rP, 32'h1);
    checkEq("R8 vector status stays 0", rV, 32'h0);
    checkEq("R4 cleared drops level", 32'(irqLevelP), 0);
    busAccess(1'b0, 8'h04, 0, rP, rV);
    checkEq("R4 status after clear", rP, 32'h0);

    // R4 event coincides with clearing read
    @(negedge clk);
    busReq = 1'b1; busWrite = 1'b0; busAddr = 8'h04; inValid = 1'b1; inVector = 16'h0001;
    #1;
    checkEq("R4 coincident ack", 32'(busAckP), 1);
    checkEq("R4 coincident read old", busRdataP, 32'h0);
    @(negedge clk);
    busReq = 1'b0; inValid = 1'b0;
    checkEq("R8 coincident pulse", 32'(irqVecV), 32'h2);
    checkEq("R4 set wins", 32'(irqLevelP), 1);
    busAccess(1'b0, 8'h04, 0, rP, rV);
    checkEq("R4 set kept", rP, 32'h1);

    // R8/R9/R11 vectors
    injectEvent("R8 vec 2", 16'h0002, 4'b0100);
    injectEvent("R8 vec 3 last", 16'h0003, 4'b1000);
    injectEvent("R8 vec 0", 16'h0000, 4'b0001);
    injectEvent("R9 vec 4 boundary", 16'h0004, 4'b0000);
    injectEvent("R9 vec ffff", 16'hFFFF, 4'b0000);
    checkEq("R11 any vector raises level", 32'(irqLevelP), 1);
    busAccess(1'b0, 8'h04, 0, rP, rV);
    checkEq("R11 status from ignored vector", rP, 32'h1);
    checkEq("R8 vector status untouched", rV, 32'h0);

    // R6/R7 doorbell
    busAccess(1'b0, 8'h0C, 0, rP, rV);
    checkEq("R6 doorbell reads 0", rP, 32'h0);
    outReady = 1'b0;
    ringBell(32'h0005_0003);
    checkEq("R6 valid raised", 32'(outValidP), 1);
    checkEq("R6 dest field", 32'(outDestP), 32'h5);
    checkEq("R6 vector field", 32'(outVectorP), 32'h3);
    fork
      ringBell(32'h0009_000A);
      begin
        repeat (3) @(negedge clk);
        #2;
        checkEq("R7 stalled", 32'(busAckP), 0);
        checkEq("R7 pending held", 32'(outDestP), 32'h5);
        @(negedge clk);
        outReady = 1'b1;
      end
    join
    repeat (2) @(negedge clk);
    checkEq("R7 drained", 32'(outValidP), 0);
    checkEq("R7 queue empty", 32'(expQ.size()), 0);
    outReady = 1'b0;

    // R10 unmapped
    busWr(8'h10, 32'hDEAD_BEEF);
    busAccess(1'b0, 8'h10, 0, rP, rV);
    checkEq("R10 high address reads 0", rP, 32'h0);
    busWr(8'h01, 32'h0);
    busAccess(1'b0, 8'h01, 0, rP, rV);
    checkEq("R10 unaligned reads 0", rP, 32'h0);
    busWr(8'h0D, 32'h0011_0022);
    checkEq("R10 unaligned bell ignored", 32'(outValidP), 0);
    busAccess(1'b0, 8'h00, 0, rP, rV);
    checkEq("R10 mask unchanged", rP, 32'h1);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule